// File: doc/BRIEF.md
# Variable Bit-Field Insert Unit

This execution unit carries out one instruction: it writes a right-justified field from a second register into a chosen slice of a destination register. The destination register is also a source. The slice is not coded in the instruction. Its starting bit and its width come from a 32-bit control register value that the caller supplies alongside the two operands.

The unit checks that the instruction word matches the fixed pattern. It then builds a merge mask as the difference of two one-hot words. It shifts the source left to the field position and selects each result bit from either the shifted source or the old destination.

Each cycle it accepts one instruction, marked by a valid strobe. There is no backpressure. It returns the merged word with a write-enable and the destination index, or it raises an exception flag instead. A parameter adds one output register stage. That stage clears with a synchronous active-high reset.

Top module: `bitfield_insert_unit`

## Requirements
- R1: The instruction matches only when bits 31:26 are 001000, bits 15:9 are 0100000, bits 8:6 are 100, bits 5:3 are 111 and bits 2:0 are 111. A valid word that differs in any of these bits raises `exc_reserved` and writes nothing.
- R2: The field start `pos` is `ctrl_reg[5:0]` and the field width `size` is `ctrl_reg[12:7]`. All other control bits have no effect on any output.
- R3: For a legal pair (pos < 32, 0 < size, pos+size <= 32), result bits at pos+size and above equal `rt_val`. Bits pos+size-1 down to pos equal the low `size` bits of `rs_val`. Bits below pos equal `rt_val`.
- R4: With pos = 0 and size = 32 the result equals `rs_val` in full.
- R5: A matching instruction with `unit_en` low raises `exc_disabled` and leaves `wr_en` low. A non-matching word raises only `exc_reserved`, whatever `unit_en` is. At most one of `wr_en`, `exc_disabled` and `exc_reserved` is high.
- R6: When `wr_en` is high, `wr_idx` equals instruction bits 25:21.
- R7: `params_bad` is high for a matching, valid instruction exactly when the pos/size pair is not legal. `wr_en` still follows R5 in that case.
- R8: With `OUT_REG` = 1 every output appears one clock after its input. Reset clears `out_valid`, `wr_en`, the exception flags and `params_bad`. A cycle with `in_valid` low produces `out_valid`, `wr_en` and both exception flags low.
- R9: Instructions issued on back-to-back cycles each produce their own correct output on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| instr | input | 32 | Instruction word |
| rt_val | input | 32 | Destination register value (also a source) |
| rs_val | input | 32 | Field source register value |
| ctrl_reg | input | 32 | Control register holding field start and width |
| unit_en | input | 1 | Unit resources enabled |
| out_valid | output | 1 | Output present |
| result | output | 32 | Merged word |
| wr_en | output | 1 | Write result to register `wr_idx` |
| wr_idx | output | 5 | Destination register index |
| exc_disabled | output | 1 | Unit-disabled exception |
| exc_reserved | output | 1 | Reserved-instruction exception |
| params_bad | output | 1 | Field start/width pair outside the legal range |

## Verification
The assertions on field contents assume a legal pos/size pair. They are gated on that condition, because an illegal pair gives an undefined result. The random stimulus draws pos from 0 to 31 and size from 1 to 32-pos, so every such instruction counts as legal. It also fills the unused control bits with random values. Illegal pairs, non-matching words and disabled cycles are driven as directed cases, and for those only the flags and the write-enable are checked.

// File: rtl/bitfield_insert_unit.sv
module bitfield_insert_unit #(
  parameter bit OUT_REG = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [31:0] instr,
  input  logic [31:0] rt_val,
  input  logic [31:0] rs_val,
  input  logic [31:0] ctrl_reg,
  input  logic        unit_en,
  output logic        out_valid,
  output logic [31:0] result,
  output logic        wr_en,
  output logic [4:0]  wr_idx,
  output logic        exc_disabled,
  output logic        exc_reserved,
  output logic        params_bad
);

  localparam logic [5:0] MAJOR = 6'b001000;
  localparam logic [6:0] MINOR = 7'b0100000;
  localparam logic [8:0] TAIL  = 9'b100_111_111;

  wire [5:0] pos  = ctrl_reg[5:0];
  wire [5:0] size = ctrl_reg[12:7];
  wire [6:0] top  = {1'b0, pos} + {1'b0, size};
  wire       unused_bits = ^{ctrl_reg[31:13], ctrl_reg[6], instr[20:16]};

  logic [31:0] k_lo;
  logic [32:0] k_hi;

  for (genvar i = 0; i < 32; i++) begin : g_lo
    assign k_lo[i] = (pos == 6'(i));
  end
  for (genvar i = 0; i < 33; i++) begin : g_hi
    assign k_hi[i] = (top == 7'(i));
  end

  wire [31:0] mask    = k_hi[31:0] - k_lo;
  wire [31:0] shifted = rs_val << pos;
  wire [31:0] merged  = (shifted & mask) | (rt_val & ~mask);

  wire is_op = (instr[31:26] == MAJOR) && (instr[15:9] == MINOR) && (instr[8:0] == TAIL);
  wire legal = (pos < 6'd32) && (size != 6'd0) && (size <= 6'd32) && (top <= 7'd32);

  wire c_wr  = in_valid & is_op & unit_en;
  wire c_dis = in_valid & is_op & ~unit_en;
  wire c_res = in_valid & ~is_op;
  wire c_bad = in_valid & is_op & ~legal;

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        out_valid    <= 1'b0;
        wr_en        <= 1'b0;
        exc_disabled <= 1'b0;
        exc_reserved <= 1'b0;
        params_bad   <= 1'b0;
      end else begin
        out_valid    <= in_valid;
        wr_en        <= c_wr;
        exc_disabled <= c_dis;
        exc_reserved <= c_res;
        params_bad   <= c_bad;
      end
      result <= merged;
      wr_idx <= instr[25:21];
    end
  end else begin : g_comb
    assign out_valid    = in_valid;
    assign wr_en        = c_wr;
    assign exc_disabled = c_dis;
    assign exc_reserved = c_res;
    assign params_bad   = c_bad;
    assign result       = merged;
    assign wr_idx       = instr[25:21];
  end

  // R3
  keep_high_chk: assert property (@(posedge clk) disable iff (rst)
    (c_wr && legal) |-> ((merged >> top) == (rt_val >> top)));
  // R3
  keep_low_chk: assert property (@(posedge clk) disable iff (rst)
    (c_wr && legal) |-> (((merged ^ rt_val) & ((32'd1 << pos) - 32'd1)) == 32'd0));
  // R3
  field_chk: assert property (@(posedge clk) disable iff (rst)
    (c_wr && legal) |-> ((((merged >> pos) ^ rs_val) & (32'hFFFF_FFFF >> (6'd32 - size))) == 32'd0));
  // R4
  full_word_chk: assert property (@(posedge clk) disable iff (rst)
    (c_wr && pos == 6'd0 && size == 6'd32) |-> (merged == rs_val));
  // R5
  one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_en, exc_disabled, exc_reserved}));
  // R8
  outcome_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en || exc_disabled || exc_reserved || params_bad) |-> out_valid);

endmodule

// File: tb/bitfield_insert_unit_bench.sv
module bitfield_insert_unit_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] instr, rt_val, rs_val, ctrl_reg;
  logic        unit_en;
  logic        out_valid, wr_en, exc_disabled, exc_reserved, params_bad;
  logic [31:0] result;
  logic [4:0]  wr_idx;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  bitfield_insert_unit #(.OUT_REG(1'b1)) u_bitfield_insert_unit (
    .clk, .rst, .in_valid, .instr, .rt_val, .rs_val, .ctrl_reg, .unit_en,
    .out_valid, .result, .wr_en, .wr_idx, .exc_disabled, .exc_reserved, .params_bad
  );

  function automatic logic [31:0] mk_instr(input logic [4:0] rt, input logic [4:0] rs);
    return {6'b001000, rt, rs, 7'b0100000, 3'b100, 3'b111, 3'b111};
  endfunction

  function automatic logic [31:0] ref_insert(input logic [31:0] rt, input logic [31:0] rs,
                                             input int p, input int s);
    logic [31:0] r;
    for (int i = 0; i < 32; i++)
      r[i] = (i >= p && i < p + s) ? rs[i - p] : rt[i];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic v, input logic [31:0] ins, input logic [31:0] rt,
                       input logic [31:0] rs, input logic [31:0] ctl, input logic en);
    @(negedge clk);
    in_valid = v; instr = ins; rt_val = rt; rs_val = rs; ctrl_reg = ctl; unit_en = en;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] mk_ctrl(input int p, input int s, input logic [31:0] junk);
    logic [31:0] c = junk;
    c[5:0] = 6'(p);
    c[12:7] = 6'(s);
    return c;
  endfunction

  task automatic legal_case(input string req, input logic [31:0] rt, input logic [31:0] rs,
                            input int p, input int s, input logic [31:0] junk);
    logic [4:0] idx = 5'($urandom);
    issue(1'b1, mk_instr(idx, 5'($urandom)), rt, rs, mk_ctrl(p, s, junk), 1'b1);
    chk(req, result, ref_insert(rt, rs, p, s));
    chk("R6", {27'd0, wr_idx}, {27'd0, idx});
    chk({req, " flags"}, {28'd0, out_valid, wr_en, exc_disabled | exc_reserved, params_bad},
        {28'd0, 1'b1, 1'b1, 1'b0, 1'b0});
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1; in_valid = 1'b0; instr = '0; rt_val = '0; rs_val = '0; ctrl_reg = '0; unit_en = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset", {27'd0, out_valid, wr_en, exc_disabled, exc_reserved, params_bad}, 32'd0);
    @(negedge clk); rst = 1'b0;

    // R3 directed
    legal_case("R3", 32'hFFFF_FFFF, 32'h0, 4, 8, 32'h0);
    legal_case("R3", 32'h1234_5678, 32'hABCD, 16, 16, 32'h0);
    legal_case("R3", 32'h0, 32'hFFFF_FFFF, 31, 1, 32'h0);
    legal_case("R3", 32'hA5A5_A5A5, 32'h3, 0, 1, 32'h0);
    // R4
    legal_case("R4", 32'hDEAD_BEEF, 32'hCAFE_F00D, 0, 32, 32'h0);
    // R2 unused control bits set
    legal_case("R2", 32'h0F0F_0F0F, 32'h5A, 8, 8, 32'hFFFF_E040);

    // R1 each fixed field corrupted
    for (int f = 0; f < 5; f++) begin
      logic [31:0] w = mk_instr(5'd3, 5'd4);
      case (f)
        0: w[30] = ~w[30];
        1: w[12] = ~w[12];
        2: w[7]  = ~w[7];
        3: w[4]  = ~w[4];
        default: w[0] = ~w[0];
      endcase
      issue(1'b1, w, 32'h1, 32'h2, mk_ctrl(0, 4, 0), f[0]);
      chk("R1", {29'd0, wr_en, exc_disabled, exc_reserved}, 32'd1);
    end

    // R5
    issue(1'b1, mk_instr(5'd7, 5'd1), 32'h1, 32'h2, mk_ctrl(2, 3, 0), 1'b0);
    chk("R5", {29'd0, wr_en, exc_disabled, exc_reserved}, 32'd2);

    // R7 illegal pairs
    issue(1'b1, mk_instr(5'd1, 5'd2), 32'h1, 32'h2, mk_ctrl(10, 0, 0), 1'b1);
    chk("R7 size0", {30'd0, params_bad, wr_en}, 32'd3);
    issue(1'b1, mk_instr(5'd1, 5'd2), 32'h1, 32'h2, mk_ctrl(20, 20, 0), 1'b1);
    chk("R7 overrun", {30'd0, params_bad, wr_en}, 32'd3);
    issue(1'b1, mk_instr(5'd1, 5'd2), 32'h1, 32'h2, mk_ctrl(40, 1, 0), 1'b1);
    chk("R7 pos", {30'd0, params_bad, wr_en}, 32'd3);
    issue(1'b1, mk_instr(5'd1, 5'd2), 32'h1, 32'h2, mk_ctrl(32, 33, 0), 1'b1);
    chk("R7 size33", {30'd0, params_bad, wr_en}, 32'd3);

    // R8 idle cycle
    issue(1'b0, mk_instr(5'd1, 5'd2), 32'h1, 32'h2, mk_ctrl(0, 4, 0), 1'b1);
    chk("R8 idle", {28'd0, out_valid, wr_en, exc_disabled, exc_reserved}, 32'd0);

    // R8 latency: output changes only after the edge
    @(negedge clk);
    in_valid = 1'b1; instr = mk_instr(5'd9, 5'd0); rt_val = 32'h0; rs_val = 32'hF;
    ctrl_reg = mk_ctrl(4, 4, 0); unit_en = 1'b1;
    #1;
    chk("R8 latency", {31'd0, out_valid}, 32'd0);
    @(posedge clk); #1;
    chk("R8 latency", result, 32'h0000_00F0);

    // R9 random back-to-back traffic
    for (int n = 0; n < 300; n++) begin
      int p = int'($urandom_range(0, 31));
      int s = int'($urandom_range(1, 32 - p));
      legal_case("R9", $urandom, $urandom, p, s, $urandom);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule